// File: doc/BRIEF.md
# Mask register logic unit

This block is a one-stage execution unit for 16-bit predicate masks. Each cycle it may accept an opcode, two mask operands and a 32-bit integer operand, qualified by a valid strobe. It computes bitwise logic on the masks, builds a mask from two low bytes, tests the OR of two masks for all-zeros and all-ones, and converts between a mask and a 32-bit integer. The answer appears on a 32-bit result port together with a zero flag and an all-ones flag, registered one cycle after the accepted input and qualified by its own valid output.

The unit sits next to a mask register file. The surrounding pipeline reads the operands, drives them with an opcode, and writes the result or the flags back one cycle later. Storage, decode and masks wider than 16 bits belong to the surrounding logic. With the strobe held high, a new operation is accepted on every clock.

Opcode encoding on `op_i` (4 bits): 0 AND, 1 AND-NOT, 2 OR, 3 XOR, 4 XNOR, 5 NOT, 6 MOVE, 7 UNPACK, 8 OR-TEST, 9 MASK-TO-INT, 10 INT-TO-MASK. Codes 11 to 15 are unused.

Top module: `mask_logic_unit`

## Requirements
- R1: Opcodes 0, 2, 3 and 6 return A AND B, A OR B, A XOR B and A, respectively, in result bits 15:0.
- R2: Opcode 1 returns (NOT A) AND B. Only operand A is inverted.
- R3: Opcode 4 returns NOT (A XOR B) across all 16 bits. Opcode 5 returns NOT A.
- R4: Opcode 7 places B[7:0] in result bits 7:0 and A[7:0] in result bits 15:8. The upper bytes of both operands have no effect.
- R5: Opcode 8 returns A OR B as the result. It raises the zero flag if and only if all 16 bits of A OR B are 0.
- R6: Opcode 8 raises the all-ones flag if and only if all 16 bits of A OR B are 1.
- R7: Opcode 9 returns A zero-extended to 32 bits. Opcode 10 returns int_i[15:0] zero-extended, so int_i[31:16] has no effect.
- R8: Opcodes 11 to 15 return a zero result and clear both flags.
- R9: Both flags are 0 after every accepted operation other than opcode 8.
- R10: Result bits 31:16 are always 0.
- R11: valid_o equals valid_i of the previous clock, and one operation is accepted per cycle.
- R12: While valid_i is low, the result and both flags hold their previous values.
- R13: An active-low asynchronous reset clears the result, both flags and valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation strobe |
| op_i | input | 4 | Opcode |
| mask_a_i | input | 16 | Mask operand A |
| mask_b_i | input | 16 | Mask operand B |
| int_i | input | 32 | Integer operand for INT-TO-MASK |
| res_o | output | 32 | Registered result |
| zero_flag_o | output | 1 | OR-test result was all zeros |
| ones_flag_o | output | 1 | OR-test result was all ones |
| valid_o | output | 1 | Result valid, one cycle after valid_i |

## Verification
The assertions assume that op_i, both masks and int_i are known (not X) in every cycle where valid_i is high. They also assume that valid_i is known in every cycle out of reset, because the hold and latency properties key on it. The bench changes its inputs only on the falling edge and always drives defined values, including during idle gaps. In those gaps it sends deliberately different operand values, so that any leak through the hold path is visible.

// File: rtl/mask_unit_pkg.sv
package mask_unit_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND      = 4'd0,
    OP_ANDN     = 4'd1,
    OP_OR       = 4'd2,
    OP_XOR      = 4'd3,
    OP_XNOR     = 4'd4,
    OP_NOT      = 4'd5,
    OP_MOV      = 4'd6,
    OP_UNPACK   = 4'd7,
    OP_ORTEST   = 4'd8,
    OP_MASK2INT = 4'd9,
    OP_INT2MASK = 4'd10
  } mask_op_e;

  function automatic logic is_bitwise(mask_op_e op);
    return op inside {OP_AND, OP_ANDN, OP_OR, OP_XOR, OP_XNOR, OP_NOT, OP_MOV};
  endfunction

  function automatic logic is_pack(mask_op_e op);
    return op inside {OP_UNPACK, OP_MASK2INT, OP_INT2MASK};
  endfunction
endpackage

// File: rtl/mask_bitwise.sv
module mask_bitwise
  import mask_unit_pkg::*;
#(
  parameter int unsigned MASK_W = 16
) (
  input  mask_op_e          op_i,
  input  logic [MASK_W-1:0] a_i,
  input  logic [MASK_W-1:0] b_i,
  output logic [MASK_W-1:0] res_o
);
  // one lane per mask bit
  for (genvar g = 0; g < MASK_W; g++) begin : g_lane
    logic a, b, r;
    assign a = a_i[g];
    assign b = b_i[g];
    always_comb begin
      unique case (op_i)
        OP_AND:  r = a & b;
        OP_ANDN: r = ~a & b;
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_XNOR: r = ~(a ^ b);
        OP_NOT:  r = ~a;
        OP_MOV:  r = a;
        default: r = 1'b0;
      endcase
    end
    assign res_o[g] = r;
  end
endmodule

// File: rtl/mask_pack.sv
module mask_pack
  import mask_unit_pkg::*;
#(
  parameter int unsigned MASK_W = 16,
  parameter int unsigned INT_W  = 32
) (
  input  mask_op_e            op_i,
  input  logic [MASK_W-1:0]   a_i,
  input  logic [MASK_W/2-1:0] b_lo_i,
  input  logic [MASK_W-1:0]   int_lo_i,
  output logic [INT_W-1:0]    res_o
);
  localparam int unsigned HALF_W = MASK_W / 2;
  localparam int unsigned PAD_W  = INT_W - MASK_W;

  logic [MASK_W-1:0] unpacked;
  assign unpacked = {a_i[HALF_W-1:0], b_lo_i};

  always_comb begin
    unique case (op_i)
      OP_UNPACK:   res_o = {{PAD_W{1'b0}}, unpacked};
      OP_MASK2INT: res_o = {{PAD_W{1'b0}}, a_i};
      OP_INT2MASK: res_o = {{PAD_W{1'b0}}, int_lo_i};
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/mask_test.sv
module mask_test #(
  parameter int unsigned MASK_W = 16
) (
  input  logic [MASK_W-1:0] a_i,
  input  logic [MASK_W-1:0] b_i,
  output logic [MASK_W-1:0] or_o,
  output logic              zero_o,
  output logic              ones_o
);
  assign or_o   = a_i | b_i;
  assign zero_o = ~|or_o;
  assign ones_o = &or_o;
endmodule

// File: rtl/mask_logic_unit.sv
module mask_logic_unit
  import mask_unit_pkg::*;
#(
  parameter int unsigned MASK_W = 16,
  parameter int unsigned INT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [MASK_W-1:0] mask_a_i,
  input  logic [MASK_W-1:0] mask_b_i,
  input  logic [INT_W-1:0]  int_i,
  output logic [INT_W-1:0]  res_o,
  output logic              zero_flag_o,
  output logic              ones_flag_o,
  output logic              valid_o
);
  localparam int unsigned HALF_W = MASK_W / 2;
  localparam int unsigned PAD_W  = INT_W - MASK_W;

  mask_op_e op;
  assign op = mask_op_e'(op_i);

  logic unused_int_hi;
  assign unused_int_hi = ^int_i[INT_W-1:MASK_W];

  logic [MASK_W-1:0] bw_res;
  logic [INT_W-1:0]  pk_res;
  logic [MASK_W-1:0] or_res;
  logic              or_zero, or_ones;

  mask_bitwise #(.MASK_W(MASK_W)) i_bitwise (
    .op_i (op),
    .a_i  (mask_a_i),
    .b_i  (mask_b_i),
    .res_o(bw_res)
  );

  mask_pack #(.MASK_W(MASK_W), .INT_W(INT_W)) i_pack (
    .op_i    (op),
    .a_i     (mask_a_i),
    .b_lo_i  (mask_b_i[HALF_W-1:0]),
    .int_lo_i(int_i[MASK_W-1:0]),
    .res_o   (pk_res)
  );

  mask_test #(.MASK_W(MASK_W)) i_test (
    .a_i   (mask_a_i),
    .b_i   (mask_b_i),
    .or_o  (or_res),
    .zero_o(or_zero),
    .ones_o(or_ones)
  );

  logic [INT_W-1:0] res_d;
  logic             zero_d, ones_d;

  always_comb begin
    res_d  = '0;
    zero_d = 1'b0;
    ones_d = 1'b0;
    if (is_bitwise(op)) begin
      res_d = {{PAD_W{1'b0}}, bw_res};
    end else if (is_pack(op)) begin
      res_d = pk_res;
    end else if (op == OP_ORTEST) begin
      res_d  = {{PAD_W{1'b0}}, or_res};
      zero_d = or_zero;
      ones_d = or_ones;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      zero_flag_o <= 1'b0;
      ones_flag_o <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o       <= res_d;
        zero_flag_o <= zero_d;
        ones_flag_o <= ones_d;
      end
    end
  end

  // R2
  andn_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ANDN) |=> res_o[MASK_W-1:0] == $past(~mask_a_i & mask_b_i));

  // R4
  unpack_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_UNPACK) |=>
      (res_o[HALF_W-1:0] == $past(mask_b_i[HALF_W-1:0]) &&
       res_o[MASK_W-1:HALF_W] == $past(mask_a_i[HALF_W-1:0])));

  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zero_flag_o && ones_flag_o));

  // R6
  ones_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ORTEST) |=> ones_flag_o == ($countones($past(mask_a_i | mask_b_i)) == MASK_W));

  // R9
  flag_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_ORTEST) |=> (!zero_flag_o && !ones_flag_o));

  // R10
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[INT_W-1:MASK_W] == '0);

  // R11
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R11
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(zero_flag_o) && $stable(ones_flag_o)));
endmodule

// File: tb/test_mask_logic_unit.sv
`timescale 1ns/1ps
module test_mask_logic_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] mask_a_i = '0, mask_b_i = '0;
  logic [31:0] int_i = '0;
  logic [31:0] res_o;
  logic        zero_flag_o, ones_flag_o, valid_o;

  always #2 clk_i = ~clk_i;

  mask_logic_unit i_mask_logic_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .mask_a_i, .mask_b_i, .int_i,
    .res_o, .zero_flag_o, .ones_flag_o, .valid_o
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_res = '0;
  logic exp_zf = 0, exp_of = 0, exp_v = 0;
  string res_tag = "R13", flag_tag = "R13";

  function automatic string op_tag(logic [3:0] op);
    case (op)
      0, 2, 3, 6: return "R1";
      1:          return "R2";
      4, 5:       return "R3";
      7:          return "R4";
      8:          return "R5";
      9, 10:      return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic compare();
    check(res_tag, res_o, exp_res);
    check(flag_tag, {31'd0, zero_flag_o}, {31'd0, exp_zf});
    check(flag_tag == "R5" ? "R6" : flag_tag, {31'd0, ones_flag_o}, {31'd0, exp_of});
    check("R10", {16'd0, res_o[31:16]}, 32'd0);
    check("R11", {31'd0, valid_o}, {31'd0, exp_v});
  endtask

  // behavioural reference
  task automatic model(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic [31:0] iv);
    int ones;
    logic [15:0] o;
    exp_zf = 0; exp_of = 0;
    case (op)
      0: exp_res = a & b;
      1: exp_res = b & ~a;
      2: exp_res = a | b;
      3: exp_res = a ^ b;
      4: exp_res = {16'd0, ~(a ^ b)};
      5: exp_res = {16'd0, ~a};
      6: exp_res = a;
      7: exp_res = (32'(a & 16'h00FF) << 8) | 32'(b & 16'h00FF);
      8: begin
        o = a | b;
        ones = 0;
        for (int k = 0; k < 16; k++) ones += o[k];
        exp_res = o;
        exp_zf = (ones == 0);
        exp_of = (ones == 16);
      end
      9:  exp_res = 32'(a);
      10: exp_res = iv % 65536;
      default: exp_res = 0;
    endcase
  endtask

  task automatic cyc(logic v, logic [3:0] op, logic [15:0] a, logic [15:0] b, logic [31:0] iv);
    @(negedge clk_i);
    compare();
    valid_i = v; op_i = op; mask_a_i = a; mask_b_i = b; int_i = iv;
    if (v) begin
      model(op, a, b, iv);
      res_tag = op_tag(op);
      flag_tag = (op == 8) ? "R5" : "R9";
    end else begin
      res_tag = "R12";
      flag_tag = "R12";
    end
    exp_v = v;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    compare();
    rst_ni = 0; valid_i = 1; op_i = 4'd5;
    exp_res = 0; exp_zf = 0; exp_of = 0; exp_v = 0;
    res_tag = "R13"; flag_tag = "R13";
    @(negedge clk_i);
    compare();
    rst_ni = 1; valid_i = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    compare();                                   // R13 reset state
    rst_ni = 1;
    cyc(1, 0, 16'hF0F0, 16'hFF00, 0);            // R1
    cyc(1, 2, 16'h1234, 16'h8001, 0);            // R1
    cyc(1, 3, 16'hAAAA, 16'hFFFF, 0);            // R1
    cyc(1, 6, 16'hBEEF, 16'h0000, 0);            // R1
    cyc(1, 1, 16'hFF00, 16'h0FF0, 0);            // R2
    cyc(1, 1, 16'h0000, 16'h5A5A, 0);            // R2
    cyc(1, 4, 16'hC3C3, 16'h0F0F, 0);            // R3
    cyc(1, 5, 16'h00FF, 16'h1234, 0);            // R3
    cyc(1, 7, 16'hAB12, 16'hCD34, 0);            // R4
    cyc(1, 7, 16'hFF00, 16'hFF00, 0);            // R4 upper bytes ignored
    cyc(1, 8, 16'h0000, 16'h0000, 0);            // R5 zero
    cyc(1, 8, 16'hFF00, 16'h00FF, 0);            // R6 all ones
    cyc(1, 8, 16'h8000, 16'h0000, 0);            // R5 R6 neither
    cyc(1, 8, 16'hFFFE, 16'h0000, 0);            // R6 one short
    cyc(1, 9, 16'hFFFF, 16'h0000, 32'hDEAD0000); // R7
    cyc(1, 10, 16'h1111, 16'h2222, 32'hDEADBEEF);// R7 upper ignored
    for (int c = 11; c < 16; c++)                // R8
      cyc(1, 4'(c), 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF);
    cyc(1, 8, 16'hFFFF, 16'hFFFF, 0);            // R6 then hold
    cyc(0, 5, 16'h1234, 16'h0000, 32'h55);       // R12
    cyc(0, 8, 16'h0000, 16'h0000, 0);            // R12
    cyc(1, 0, 16'hFFFF, 16'hFFFF, 0);            // R9 clears flags
    do_reset();                                  // R13
    for (int n = 0; n < 400; n++)                // R11 back-to-back
      cyc(($urandom % 5) != 0, 4'($urandom % 16), 16'($urandom),
          16'($urandom), $urandom);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule